// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Port Master

This block moves multi-bit tuning fields into and out of a PHY whose only configuration path is a one-bit serial test port. Every bit of a field lives at its own 8-bit bit address, so a field of N bits takes N port transactions at consecutive addresses. A client issues a single command (write or read, start address, length of 0 to 16 bits, write data). The block then sequences the port's enable, address byte, data-in bit and strobe, and samples the port's status bit on reads.

Writes go out least significant bit first. Bit j of the data goes to address start+j. Each bit is committed by a clean strobe pulse whose high and low phases are held for a parameterised number of cycles. Reads visit the addresses from the top of the field downward and hold each address for a fixed settle time before sampling, so the highest address ends up in the most significant bit of the result. The result is presented on a hold register that keeps its value until the next command is accepted.

Top module: `tune_port_master`

## Requirements
- R1: After reset, port_en, port_strobe and port_din are 0, port_addr is 0, busy and done are 0, and rd_data is 0.
- R2: On acceptance of a nonzero-length command, port_en rises in the next cycle and stays high for STROBE_CYC cycles before the first bit address is driven. It falls in the same cycle in which done pulses, after the last bit.
- R3: A write of length N sends bit j of cmd_wdata to address cmd_addr+j, for j = 0 up to N-1. Each bit runs four phases of STROBE_CYC cycles each: the new address with the strobe low, then the data bit, then the strobe high, then the strobe low. The address and data bit are stable when the strobe rises.
- R4: A read of length N drives addresses cmd_addr+N-1 down to cmd_addr, each for SETTLE_CYC cycles, and samples port_status in the last cycle of each address. Each sample is shifted in at bit 0 as the result moves left, so the highest address lands in result bit N-1; the bits above N-1 are 0.
- R5: done is high for exactly one cycle, in the cycle after the last phase ends. busy is high from the cycle after acceptance until that done cycle, and is low during it.
- R6: rd_data is cleared to 0 in the cycle after any command is accepted. It is loaded with the read result in the done cycle and then held until the next accepted command.
- R7: A command presented while busy is high is ignored: the port sequence, done timing and rd_data are those of the transfer already running.
- R8: A command of length 0 produces done in the next cycle, with busy, port_en and port_strobe staying low and port_addr and port_din unchanged.
- R9: A length above 16 is treated as 16. Addresses beyond start+15 are neither driven nor written.
- R10: Bit addresses wrap modulo 256, so a field starting at 0xFE with length 4 uses 0xFE, 0xFF, 0x00 and 0x01.
- R11: port_addr and port_din keep their last driven values between transfers. A read never raises port_strobe and never changes port_din.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command request, sampled when not busy |
| cmd_write | input | 1 | 1 = write field, 0 = read field |
| cmd_addr | input | 8 | Start bit address of the field |
| cmd_len | input | 5 | Field length in bits (0 to 16, larger clamps to 16) |
| cmd_wdata | input | 16 | Write data, bit 0 sent first |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, held until next command |
| port_en | output | 1 | Test port enable |
| port_addr | output | 8 | Test port bit address |
| port_din | output | 1 | Test port data-in bit |
| port_strobe | output | 1 | Test port write strobe |
| port_status | input | 1 | Test port status bit for the addressed bit |

## Verification
The block is driven against a bit-array PHY model with a known pre-loaded pattern. Writes use mixed-bit values of 5 and 16 bits, so a reversed bit order or an off-by-one address shows up at once. Reads of those same fields, and of untouched pattern regions, tell an upward walk from the required downward walk and show whether the MSB lands correctly. A short write whose data has set upper bits, an over-long length, a field that crosses address 0xFF, zero-length commands and a command poked mid-transfer separate the clamp, wrap, no-activity and ignore rules from the normal path. A cycle-accurate expected trace compared every clock pins down phase lengths, the enable window and the done and rd_data timing.

// File: rtl/tpm_pkg.sv
// Shared types for the tuning port master.
// Assumes nothing beyond a single clock domain.
package tpm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ENA,
        S_WADDR,
        S_WDATA,
        S_WHIGH,
        S_WLOW,
        S_RWAIT
    } tpm_state_e;
endpackage

// File: rtl/tpm_phase_timer.sv
// Phase timer: a load of value V makes expire go high in the V-th cycle
// after the load edge, so a phase entered on a load lasts V cycles.
// Assumes load_val is never zero.
module tpm_phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    // Count down the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expire = (cnt_q == '0);

    AST_TIMER_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R3
endmodule

// File: rtl/tpm_field_path.sv
// Field datapath: holds the bit address pointer, the write shift register,
// the read accumulator and the bits-left count for one transfer.
// Assumes the controller asserts step only while bits remain.
module tpm_field_path #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int LEN_W   = 5,
    parameter int MAX_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_write,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic [DATA_W-1:0] load_data,
    input  logic              step,
    input  logic              sample,
    input  logic              status,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic              cur_bit,
    output logic              last,
    output logic              empty,
    output logic [DATA_W-1:0] acc_next
);
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] acc_q;
    logic [LEN_W-1:0]  left_q;
    logic              up_q;
    logic [LEN_W-1:0]  len_eff;

    // Clamp oversize lengths to the field maximum.
    always_comb begin
        len_eff = (load_len > LEN_CAP) ? LEN_CAP : load_len;
    end

    // Writes walk upward from the start, reads downward from the top bit.
    assign next_addr = up_q ? (addr_q + ADDR_W'(1)) : (addr_q - ADDR_W'(1));
    assign cur_addr  = addr_q;
    assign cur_bit   = shreg_q[0];
    assign last      = (left_q == LEN_W'(1));
    assign empty     = (left_q == '0);
    assign acc_next  = {acc_q[DATA_W-2:0], status};

    // Load a new field or advance one bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            shreg_q <= '0;
            acc_q   <= '0;
            left_q  <= '0;
            up_q    <= 1'b0;
        end else if (load) begin
            up_q    <= load_write;
            left_q  <= len_eff;
            shreg_q <= load_data;
            acc_q   <= '0;
            addr_q  <= load_write ? load_addr
                                  : (load_addr + ADDR_W'(len_eff) - ADDR_W'(1));
        end else begin
            if (step) begin
                left_q  <= left_q - LEN_W'(1);
                addr_q  <= next_addr;
                shreg_q <= shreg_q >> 1;
            end
            if (sample) begin
                acc_q <= acc_next;
            end
        end
    end

    AST_LEFT_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= LEN_CAP); // R9
    AST_STEP_HAS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !empty); // R3
    AST_SAMPLE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> !up_q); // R4
endmodule

// File: rtl/tpm_ctrl.sv
// Sequencer: accepts commands, steps through enable, per-bit write phases
// or per-bit read settle windows, and owns every registered output.
// Assumes the phase timer and field datapath are driven only from here.
module tpm_ctrl
    import tpm_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int LEN_W      = 5,
    parameter int STROBE_CYC = 2,
    parameter int SETTLE_CYC = 4,
    parameter int CW         = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              expire,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic              cur_bit,
    input  logic              last,
    input  logic              empty,
    input  logic [DATA_W-1:0] acc_next,
    output logic              tmr_load,
    output logic [CW-1:0]     tmr_val,
    output logic              fp_load,
    output logic              fp_step,
    output logic              fp_sample,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              port_en,
    output logic [ADDR_W-1:0] port_addr,
    output logic              port_din,
    output logic              port_strobe
);
    localparam logic [CW-1:0] PH_LD = CW'(STROBE_CYC);
    localparam logic [CW-1:0] SW_LD = CW'(SETTLE_CYC);

    tpm_state_e state_q;
    logic       is_wr_q;

    // Decide timer loads and datapath moves for the current state.
    always_comb begin
        tmr_load  = 1'b0;
        tmr_val   = PH_LD;
        fp_load   = 1'b0;
        fp_step   = 1'b0;
        fp_sample = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    fp_load  = 1'b1;
                    tmr_load = (cmd_len != '0);
                end
            end
            S_ENA: begin
                if (expire) begin
                    tmr_load = 1'b1;
                    tmr_val  = is_wr_q ? PH_LD : SW_LD;
                end
            end
            S_WADDR, S_WHIGH: begin
                tmr_load = expire;
            end
            S_WDATA: begin
                tmr_load = expire;
                fp_step  = expire;
            end
            S_WLOW: begin
                tmr_load = expire && !empty;
            end
            S_RWAIT: begin
                if (expire) begin
                    fp_step   = 1'b1;
                    fp_sample = 1'b1;
                    tmr_load  = !last;
                    tmr_val   = SW_LD;
                end
            end
            default: begin
                tmr_load = 1'b0;
            end
        endcase
    end

    // Advance the sequence and update the port and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            is_wr_q     <= 1'b0;
            busy        <= 1'b0;
            done        <= 1'b0;
            rd_data     <= '0;
            port_en     <= 1'b0;
            port_addr   <= '0;
            port_din    <= 1'b0;
            port_strobe <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (cmd_valid) begin
                        rd_data <= '0;
                        if (cmd_len == '0) begin
                            done <= 1'b1;
                        end else begin
                            busy    <= 1'b1;
                            port_en <= 1'b1;
                            is_wr_q <= cmd_write;
                            state_q <= S_ENA;
                        end
                    end
                end
                S_ENA: begin
                    if (expire) begin
                        port_addr <= cur_addr;
                        state_q   <= is_wr_q ? S_WADDR : S_RWAIT;
                    end
                end
                S_WADDR: begin
                    if (expire) begin
                        port_din <= cur_bit;
                        state_q  <= S_WDATA;
                    end
                end
                S_WDATA: begin
                    if (expire) begin
                        port_strobe <= 1'b1;
                        state_q     <= S_WHIGH;
                    end
                end
                S_WHIGH: begin
                    if (expire) begin
                        port_strobe <= 1'b0;
                        state_q     <= S_WLOW;
                    end
                end
                S_WLOW: begin
                    if (expire) begin
                        if (empty) begin
                            port_en <= 1'b0;
                            busy    <= 1'b0;
                            done    <= 1'b1;
                            state_q <= S_IDLE;
                        end else begin
                            port_addr <= cur_addr;
                            state_q   <= S_WADDR;
                        end
                    end
                end
                S_RWAIT: begin
                    if (expire) begin
                        if (last) begin
                            rd_data <= acc_next;
                            port_en <= 1'b0;
                            busy    <= 1'b0;
                            done    <= 1'b1;
                            state_q <= S_IDLE;
                        end else begin
                            port_addr <= next_addr;
                        end
                    end
                end
                default: begin
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    AST_STROBE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        port_strobe |-> (port_en && is_wr_q)); // R3
    AST_STROBE_SETUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_strobe) |-> ($stable(port_addr) && $stable(port_din))); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R5
    AST_EN_DROPS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(port_en) |-> done); // R2
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> $stable(rd_data)); // R6
endmodule

// File: rtl/tune_port_master.sv
// Top: bit-serial tuning port master. Moves fields of up to MAX_LEN bits
// one bit per port transaction at consecutive bit addresses.
// Assumes STROBE_CYC >= 2 and SETTLE_CYC >= 1; port_status is valid for the
// addressed bit within SETTLE_CYC cycles of an address change.
module tune_port_master #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int MAX_LEN    = 16,
    parameter int STROBE_CYC = 2,
    parameter int SETTLE_CYC = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic                         cmd_write,
    input  logic [ADDR_W-1:0]            cmd_addr,
    input  logic [$clog2(MAX_LEN+1)-1:0] cmd_len,
    input  logic [DATA_W-1:0]            cmd_wdata,
    output logic                         busy,
    output logic                         done,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         port_en,
    output logic [ADDR_W-1:0]            port_addr,
    output logic                         port_din,
    output logic                         port_strobe,
    input  logic                         port_status
);
    localparam int LEN_W = $clog2(MAX_LEN + 1);
    localparam int MAXC  = (STROBE_CYC > SETTLE_CYC) ? STROBE_CYC : SETTLE_CYC;
    localparam int CW    = $clog2(MAXC + 1);

    logic              tmr_load;
    logic [CW-1:0]     tmr_val;
    logic              expire;
    logic              fp_load;
    logic              fp_step;
    logic              fp_sample;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] next_addr;
    logic              cur_bit;
    logic              last;
    logic              empty;
    logic [DATA_W-1:0] acc_next;

    tpm_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (expire)
    );

    tpm_field_path #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .LEN_W   (LEN_W),
        .MAX_LEN (MAX_LEN)
    ) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (fp_load),
        .load_write (cmd_write),
        .load_addr  (cmd_addr),
        .load_len   (cmd_len),
        .load_data  (cmd_wdata),
        .step       (fp_step),
        .sample     (fp_sample),
        .status     (port_status),
        .cur_addr   (cur_addr),
        .next_addr  (next_addr),
        .cur_bit    (cur_bit),
        .last       (last),
        .empty      (empty),
        .acc_next   (acc_next)
    );

    tpm_ctrl #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LEN_W      (LEN_W),
        .STROBE_CYC (STROBE_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .CW         (CW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_write   (cmd_write),
        .cmd_len     (cmd_len),
        .expire      (expire),
        .cur_addr    (cur_addr),
        .next_addr   (next_addr),
        .cur_bit     (cur_bit),
        .last        (last),
        .empty       (empty),
        .acc_next    (acc_next),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .fp_load     (fp_load),
        .fp_step     (fp_step),
        .fp_sample   (fp_sample),
        .busy        (busy),
        .done        (done),
        .rd_data     (rd_data),
        .port_en     (port_en),
        .port_addr   (port_addr),
        .port_din    (port_din),
        .port_strobe (port_strobe)
    );

    AST_ZERO_LEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && (cmd_len == '0)) |=> (!port_en && done)); // R8
endmodule

// File: tb/tune_port_master_test.sv
module tune_port_master_test;
    localparam int PH = 2;
    localparam int SW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [7:0]  cmd_addr = '0;
    logic [4:0]  cmd_len = '0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, done, port_en, port_din, port_strobe, port_status;
    logic [15:0] rd_data;
    logic [7:0]  port_addr;

    logic [255:0] phy_mem;
    logic [255:0] model_mem;

    int checks = 0;
    int failures = 0;

    logic [28:0] q[$];
    logic        m_din = 1'b0;
    logic [7:0]  m_addr = '0;
    logic [15:0] m_rd = '0;

    always #5 clk = ~clk;

    tune_port_master #(
        .STROBE_CYC (PH),
        .SETTLE_CYC (SW)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_write   (cmd_write),
        .cmd_addr    (cmd_addr),
        .cmd_len     (cmd_len),
        .cmd_wdata   (cmd_wdata),
        .busy        (busy),
        .done        (done),
        .rd_data     (rd_data),
        .port_en     (port_en),
        .port_addr   (port_addr),
        .port_din    (port_din),
        .port_strobe (port_strobe),
        .port_status (port_status)
    );

    // Behavioural PHY bit array: commit on strobe rise, status is the addressed bit.
    always @(posedge port_strobe) phy_mem[port_addr] <= port_din;
    assign port_status = phy_mem[port_addr];

    function automatic logic [28:0] snap(input logic b, input logic d, input logic e,
                                         input logic s, input logic din,
                                         input logic [7:0] a, input logic [15:0] r);
        return {b, d, e, s, din, a, r};
    endfunction

    // Build the expected per-cycle trace for one accepted command.
    task automatic expand(input logic w, input logic [7:0] a, input int l, input logic [15:0] d);
        int n;
        logic [15:0] acc;
        n = (l > 16) ? 16 : l;
        m_rd = '0;
        if (n == 0) begin
            q.push_back(snap(0, 1, 0, 0, m_din, m_addr, 16'h0));
            return;
        end
        repeat (PH) q.push_back(snap(1, 0, 1, 0, m_din, m_addr, 16'h0));
        if (w) begin
            for (int j = 0; j < n; j++) begin
                m_addr = a + 8'(j);
                repeat (PH) q.push_back(snap(1, 0, 1, 0, m_din, m_addr, 16'h0));
                m_din = d[j];
                repeat (PH) q.push_back(snap(1, 0, 1, 0, m_din, m_addr, 16'h0));
                repeat (PH) q.push_back(snap(1, 0, 1, 1, m_din, m_addr, 16'h0));
                repeat (PH) q.push_back(snap(1, 0, 1, 0, m_din, m_addr, 16'h0));
                model_mem[m_addr] = m_din;
            end
        end else begin
            acc = '0;
            for (int j = n - 1; j >= 0; j--) begin
                m_addr = a + 8'(j);
                repeat (SW) q.push_back(snap(1, 0, 1, 0, m_din, m_addr, 16'h0));
                acc = {acc[14:0], model_mem[m_addr]};
            end
            m_rd = acc;
        end
        q.push_back(snap(0, 1, 0, 0, m_din, m_addr, m_rd));
    endtask

    // One clock: release the request, then compare outputs to the model at the falling edge.
    task automatic tick(input string tag);
        logic [28:0] exp_v;
        logic [28:0] act_v;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (q.size() > 0) exp_v = q.pop_front();
        else exp_v = snap(0, 0, 0, 0, m_din, m_addr, m_rd);
        act_v = {busy, done, port_en, port_strobe, port_din, port_addr, rd_data};
        checks++;
        if (act_v !== exp_v) begin
            failures++;
            $display("FAIL %s trace t=%0t actual=%h expected=%h", tag, $time, act_v, exp_v);
        end
    endtask

    task automatic drain(input string tag);
        while (q.size() > 0) tick(tag);
        tick(tag);
    endtask

    task automatic issue(input logic w, input logic [7:0] a, input int l,
                         input logic [15:0] d, input string tag);
        cmd_valid = 1'b1;
        cmd_write = w;
        cmd_addr  = a;
        cmd_len   = 5'(l);
        cmd_wdata = d;
        expand(w, a, l, d);
        tick(tag);
    endtask

    task automatic check_val(input logic [15:0] act, input logic [15:0] exp_v, input string tag);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s value actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R5 watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) phy_mem[i] = ((i * 37 + (i >> 3)) % 3) == 1;
        model_mem = phy_mem;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_val({busy, done, port_en, port_strobe, port_din, 3'b0, port_addr}, 16'h0, "R1");
        check_val(rd_data, 16'h0, "R1");
        tick("R1");

        // R3 R2 R5: 5-bit write
        issue(1'b1, 8'h20, 5, 16'h0014, "R3");
        drain("R3");
        // R4: read it back
        issue(1'b0, 8'h20, 5, 16'h0, "R4");
        drain("R4");
        check_val(rd_data, 16'h0014, "R4");
        // R4 R11: read an untouched pattern field
        issue(1'b0, 8'h03, 6, 16'hFFFF, "R11");
        drain("R11");
        // R3 R4: full 16-bit field
        issue(1'b1, 8'h40, 16, 16'hA5C3, "R3");
        drain("R3");
        issue(1'b0, 8'h40, 16, 16'h0, "R4");
        drain("R4");
        check_val(rd_data, 16'hA5C3, "R4");
        // R3: only low bits of data written for a short field
        issue(1'b1, 8'h1c, 3, 16'hFFF9, "R3");
        drain("R3");
        issue(1'b0, 8'h1c, 3, 16'h0, "R3");
        drain("R3");
        check_val(rd_data, 16'h0001, "R3");
        // R6: result held while idle
        repeat (5) tick("R6");
        check_val(rd_data, 16'h0001, "R6");
        // R8 R6: zero-length commands clear result, no port activity
        issue(1'b0, 8'h77, 0, 16'h0, "R8");
        drain("R8");
        check_val(rd_data, 16'h0, "R8");
        issue(1'b1, 8'h55, 0, 16'hFFFF, "R8");
        drain("R8");
        // R9: over-long length clamps to 16
        issue(1'b1, 8'h80, 20, 16'h3C5A, "R9");
        drain("R9");
        issue(1'b0, 8'h90, 4, 16'h0, "R9");
        drain("R9");
        check_val(rd_data, {12'h0, phy_mem[8'h93], phy_mem[8'h92], phy_mem[8'h91], phy_mem[8'h90]}, "R9");
        issue(1'b0, 8'h80, 16, 16'h0, "R9");
        drain("R9");
        check_val(rd_data, 16'h3C5A, "R9");
        // R10: address wrap
        issue(1'b1, 8'hFE, 4, 16'h000B, "R10");
        drain("R10");
        issue(1'b0, 8'hFE, 4, 16'h0, "R10");
        drain("R10");
        check_val(rd_data, 16'h000B, "R10");
        // R7: commands during busy are ignored
        issue(1'b1, 8'h30, 4, 16'h0006, "R7");
        repeat (6) tick("R7");
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 8'h10; cmd_len = 5'd0; cmd_wdata = '0;
        tick("R7");
        repeat (9) tick("R7");
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 8'h00; cmd_len = 5'd8; cmd_wdata = 16'hFF;
        tick("R7");
        drain("R7");
        issue(1'b0, 8'h30, 4, 16'h0, "R7");
        drain("R7");
        check_val(rd_data, 16'h0006, "R7");
        check_val({15'h0, phy_mem[8'h00]}, {15'h0, model_mem[8'h00]}, "R7");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule